// File: doc/BRIEF.md
# Keyboard Command Responder

This block plays the keyboard end of one serial channel. It turns raw key events into target key codes, answers a small set of host commands with fixed two-byte replies, and holds every outgoing byte in a 256-entry byte queue. The host's receive path reads that queue. The head of the queue is always on the output, together with a flag that says whether any byte is waiting. A read strobe removes the head byte.

Key events carry a 7-bit raw code and a release flag. The raw code selects an entry in a constant translation table. The release flag is placed in bit 7 of the translated code without any change. Host command bytes arrive on a separate strobe. Two command values produce replies. Every other command value is dropped.

At most one byte enters the queue in any cycle. Key codes come before reply bytes when both are ready. The two bytes of a reply always enter the queue in consecutive cycles, with nothing between them.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset, `rx_avail` is 0 and `head_byte` is 0x00.
- R2: A raw code c below MAPPED_KEYS (default 100) translates to c+1. Every other raw code translates to 0. The release flag is ORed into bit 7 of the queued byte.
- R3: A key event enters the queue in the cycle of its strobe, provided no reply is being emitted and no earlier key is waiting. If the queue was empty, `head_byte` shows the key's byte right after that clock edge and `rx_avail` is 1.
- R4: Command byte 0x01 queues 0xFF and then 0x05.
- R5: Command byte 0x07 queues 0xFE and then 0x20.
- R6: Any other command byte leaves the queue unchanged.
- R7: A key event given in the same cycle as a command, or before the reply starts, is queued ahead of the reply. The two reply bytes enter the queue in consecutive cycles. A key event that arrives between them is held and queued directly after the second byte. Keys that follow keep their order.
- R8: A command that arrives while an earlier reply is still waiting or being emitted is ignored.
- R9: The queue returns bytes in arrival order and holds 256 of them. Any push made while it holds 256 bytes is dropped, including reply bytes.
- R10: When the queue is empty, `head_byte` is 0x00 and `rx_avail` is 0. A read strobe then has no effect.
- R11: A read and a push in the same cycle both take effect.
- R12: After a read, `rx_avail` stays 1 as long as bytes remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_stb | input | 1 | Key event strobe |
| key_code | input | 7 | Raw key code |
| key_release | input | 1 | Key release flag |
| cmd_stb | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Host command byte |
| rd_stb | input | 1 | Host read strobe; removes the head byte |
| head_byte | output | 8 | Head of the queue, 0x00 when empty |
| rx_avail | output | 1 | At least one byte is queued |

## Verification
Assertions check four things on every cycle:
- every key strobe produces a push to the queue;
- a started reply always pushes its second byte in the next cycle;
- the hold register for a deferred key is never in use while a reply is half-emitted;
- an empty queue shows 0x00 and ignores reads, and a full queue never grows.

Only the bench's scenarios can show the byte order for each timing of key against command, the translated values and the reply contents. The same holds for dropping on overflow and for dropping commands that arrive while a reply is busy.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int BYTE_W = 8;
  localparam int RAW_W  = 7;

  localparam logic [7:0] CMD_RESET  = 8'h01;
  localparam logic [7:0] CMD_LAYOUT = 8'h07;

  localparam logic [7:0] RST_REPLY0 = 8'hFF;
  localparam logic [7:0] RST_REPLY1 = 8'h05;
  localparam logic [7:0] LAY_REPLY0 = 8'hFE;
  localparam logic [7:0] LAY_REPLY1 = 8'h20;

  typedef enum logic [0:0] {
    REPLY_RESET  = 1'b0,
    REPLY_LAYOUT = 1'b1
  } reply_kind_e;
endpackage

// File: rtl/kbd_keymap.sv
module kbd_keymap #(
  parameter int MAPPED_KEYS = 100
) (
  input  logic [kbd_pkg::RAW_W-1:0]  raw_code,
  input  logic                       release_flag,
  output logic [kbd_pkg::BYTE_W-1:0] code_out
);
  localparam int ENTRIES = 1 << kbd_pkg::RAW_W;

  logic [kbd_pkg::RAW_W-1:0] lut [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
    assign lut[i] = (i < MAPPED_KEYS) ? kbd_pkg::RAW_W'(i + 1) : '0;
  end

  assign code_out = {release_flag, lut[raw_code]};
endmodule

// File: rtl/kbd_reply_seq.sv
module kbd_reply_seq
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              key_stb,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              cmd_stb,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              push_v,
  output logic [BYTE_W-1:0] push_d
);
  logic              pend_q;
  logic              second_q;
  reply_kind_e       kind_q;
  logic              hold_v_q;
  logic [BYTE_W-1:0] hold_d_q;

  logic is_rst, is_lay, accept;
  logic start, hold_load, hold_drain;
  logic [BYTE_W-1:0] first_b, second_b;

  assign is_rst = (cmd_byte == CMD_RESET);
  assign is_lay = (cmd_byte == CMD_LAYOUT);
  assign accept = cmd_stb && (is_rst || is_lay) && !pend_q && !second_q;

  assign first_b  = (kind_q == REPLY_LAYOUT) ? LAY_REPLY0 : RST_REPLY0;
  assign second_b = (kind_q == REPLY_LAYOUT) ? LAY_REPLY1 : RST_REPLY1;

  always_comb begin
    push_v     = 1'b0;
    push_d     = '0;
    start      = 1'b0;
    hold_load  = 1'b0;
    hold_drain = 1'b0;
    if (second_q) begin
      push_v    = 1'b1;
      push_d    = second_b;
      hold_load = key_stb;
    end else if (hold_v_q) begin
      push_v     = 1'b1;
      push_d     = hold_d_q;
      hold_load  = key_stb;
      hold_drain = !key_stb;
    end else if (key_stb) begin
      push_v = 1'b1;
      push_d = key_byte;
    end else if (pend_q) begin
      push_v = 1'b1;
      push_d = first_b;
      start  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      second_q <= 1'b0;
      kind_q   <= REPLY_RESET;
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else begin
      if (start) begin
        pend_q   <= 1'b0;
        second_q <= 1'b1;
      end else if (second_q) begin
        second_q <= 1'b0;
      end
      if (accept) begin
        pend_q <= 1'b1;
        kind_q <= is_lay ? REPLY_LAYOUT : REPLY_RESET;
      end
      if (hold_load) begin
        hold_v_q <= 1'b1;
        hold_d_q <= key_byte;
      end else if (hold_drain) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  assert_key_pushed_R3: assert property (@(posedge clk) disable iff (rst)
    key_stb |-> push_v)
    else $error("key strobe without a queue push");

  assert_reply_adjacent_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> (push_v && push_d == $past(second_b)))
    else $error("reply second byte not pushed right after the first");

  assert_hold_free_R7: assert property (@(posedge clk) disable iff (rst)
    second_q |-> !hold_v_q)
    else $error("deferred key present during reply emission");

  assert_busy_cmd_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && second_q) |=> !pend_q)
    else $error("command accepted while reply emitting");
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_v,
  input  logic [WIDTH-1:0] push_d,
  input  logic             rd_stb,
  output logic [WIDTH-1:0] head,
  output logic             avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, rd_ptr_n;
  logic [CW-1:0]    count, count_n;
  logic [WIDTH-1:0] head_q;
  logic             avail_q;
  logic             full, push_ok, rd_ok;

  assign full    = (count == FULL_CNT);
  assign push_ok = push_v && !full;
  assign rd_ok   = rd_stb && (count != '0);

  always_comb begin
    rd_ptr_n = rd_ok ? AW'(rd_ptr + 1'b1) : rd_ptr;
    count_n  = count;
    if (push_ok && !rd_ok)      count_n = count + 1'b1;
    else if (!push_ok && rd_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      head_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= AW'(wr_ptr + 1'b1);
      rd_ptr  <= rd_ptr_n;
      count   <= count_n;
      avail_q <= (count_n != '0);
      if (count_n == '0)
        head_q <= '0;
      else if (push_ok && wr_ptr == rd_ptr_n)
        head_q <= push_d;
      else
        head_q <= mem[rd_ptr_n];
    end
  end

  assign head  = head_q;
  assign avail = avail_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_stb) |=> (count == FULL_CNT && $stable(wr_ptr)))
    else $error("full queue accepted a push");

  assert_empty_head_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !avail_q |-> (head_q == '0))
    else $error("empty queue shows a nonzero head");

  assert_empty_read_noop_R10: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rd_stb && !push_v) |=> (count == '0 && $stable(rd_ptr)))
    else $error("read of empty queue changed state");

  assert_dual_op_R11: assert property (@(posedge clk) disable iff (rst)
    (push_v && rd_stb && count != '0 && !full) |=> $stable(count))
    else $error("simultaneous push and read changed the count");
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder #(
  parameter int QUEUE_DEPTH = 256,
  parameter int MAPPED_KEYS = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_stb,
  input  logic [6:0] key_code,
  input  logic       key_release,
  input  logic       cmd_stb,
  input  logic [7:0] cmd_byte,
  input  logic       rd_stb,
  output logic [7:0] head_byte,
  output logic       rx_avail
);
  logic [7:0] key_byte;
  logic       push_v;
  logic [7:0] push_d;

  kbd_keymap #(.MAPPED_KEYS(MAPPED_KEYS)) u_map (
    .raw_code     (key_code),
    .release_flag (key_release),
    .code_out     (key_byte)
  );

  kbd_reply_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .key_stb  (key_stb),
    .key_byte (key_byte),
    .cmd_stb  (cmd_stb),
    .cmd_byte (cmd_byte),
    .push_v   (push_v),
    .push_d   (push_d)
  );

  kbd_byte_queue #(.DEPTH(QUEUE_DEPTH), .WIDTH(8)) u_q (
    .clk    (clk),
    .rst    (rst),
    .push_v (push_v),
    .push_d (push_d),
    .rd_stb (rd_stb),
    .head   (head_byte),
    .avail  (rx_avail)
  );

  assert_push_sets_avail_R3: assert property (@(posedge clk) disable iff (rst)
    (key_stb && !rx_avail && !rd_stb) |=> rx_avail)
    else $error("key into empty queue did not raise rx_avail");
endmodule

// File: tb/tb_kbd_cmd_responder.sv
module tb_kbd_cmd_responder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_stb = 1'b0;
  logic [6:0] key_code = '0;
  logic       key_release = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] head_byte;
  logic       rx_avail;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  kbd_cmd_responder dut (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_code(key_code),
    .key_release(key_release), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
    .rd_stb(rd_stb), .head_byte(head_byte), .rx_avail(rx_avail)
  );

  function automatic logic [7:0] xlate(input int c, input logic rel);
    logic [6:0] t;
    t = (c < 100) ? 7'(c + 1) : 7'd0;
    return {rel, t};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key(input int c, input logic rel);
    key_stb = 1'b1; key_code = 7'(c); key_release = rel;
    @(negedge clk);
    key_stb = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_stb = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) begin
      chk({tag, " avail"}, int'(rx_avail), 1);
      chk({tag, " head"}, int'(head_byte), int'(exp_q.pop_front()));
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
    end
    chk({tag, " empty avail"}, int'(rx_avail), 0);
    chk({tag, " empty head"}, int'(head_byte), 0);
  endtask

  task automatic t_reset();
    chk("R1 avail", int'(rx_avail), 0);
    chk("R1 head", int'(head_byte), 0);
  endtask

  task automatic t_keys();
    key(0, 1'b0);
    chk("R3 avail after key", int'(rx_avail), 1);
    chk("R3 head after key", int'(head_byte), 8'h01);
    exp_q.push_back(xlate(0, 1'b0));
    key(5, 1'b1);   exp_q.push_back(xlate(5, 1'b1));
    key(99, 1'b0);  exp_q.push_back(xlate(99, 1'b0));
    key(100, 1'b0); exp_q.push_back(xlate(100, 1'b0));
    key(127, 1'b1); exp_q.push_back(xlate(127, 1'b1));
    drain("R2 translation");
  endtask

  task automatic t_cmds();
    cmd(8'h01); idle(3);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h05);
    drain("R4 reset reply");
    cmd(8'h07); idle(3);
    exp_q.push_back(8'hFE); exp_q.push_back(8'h20);
    drain("R5 layout reply");
    cmd(8'h02); cmd(8'h00); cmd(8'hFF); cmd(8'h06); idle(3);
    chk("R6 other cmds avail", int'(rx_avail), 0);
    chk("R6 other cmds head", int'(head_byte), 0);
  endtask

  task automatic t_order();
    key_stb = 1'b1; key_code = 7'd10; key_release = 1'b0;
    cmd_stb = 1'b1; cmd_byte = 8'h01;
    @(negedge clk);
    key_stb = 1'b0; cmd_stb = 1'b0;
    idle(3);
    exp_q.push_back(xlate(10, 1'b0)); exp_q.push_back(8'hFF); exp_q.push_back(8'h05);
    drain("R7 same cycle");

    cmd(8'h07); key(20, 1'b0); idle(3);
    exp_q.push_back(xlate(20, 1'b0)); exp_q.push_back(8'hFE); exp_q.push_back(8'h20);
    drain("R7 key before start");

    cmd(8'h01); idle(1); key(30, 1'b0); key(31, 1'b1); key(32, 1'b0); idle(3);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h05);
    exp_q.push_back(xlate(30, 1'b0)); exp_q.push_back(xlate(31, 1'b1));
    exp_q.push_back(xlate(32, 1'b0));
    drain("R7 key mid reply");
  endtask

  task automatic t_busy();
    cmd(8'h01); cmd(8'h07); idle(3);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h05);
    drain("R8 cmd while pending");
    cmd(8'h01); idle(1); cmd(8'h07); idle(3);
    exp_q.push_back(8'hFF); exp_q.push_back(8'h05);
    drain("R8 cmd while emitting");
    cmd(8'h07); idle(3);
    exp_q.push_back(8'hFE); exp_q.push_back(8'h20);
    drain("R8 cmd accepted when idle");
  endtask

  task automatic t_full();
    for (int i = 0; i < 256; i++) begin
      key(i % 128, i[7]);
      exp_q.push_back(xlate(i % 128, i[7]));
    end
    key(3, 1'b0); key(4, 1'b0); key(5, 1'b0);
    cmd(8'h01); idle(4);
    drain("R9 full queue");
  endtask

  task automatic t_empty();
    chk("R10 empty avail", int'(rx_avail), 0);
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    chk("R10 after empty read avail", int'(rx_avail), 0);
    chk("R10 after empty read head", int'(head_byte), 0);
    key(40, 1'b0);
    chk("R10 queue intact after empty read", int'(head_byte), int'(xlate(40, 1'b0)));
    exp_q.push_back(xlate(40, 1'b0));
    drain("R10 follow-up");
  endtask

  task automatic t_dual();
    key(50, 1'b0); key(51, 1'b0);
    rd_stb = 1'b1; key_stb = 1'b1; key_code = 7'd52; key_release = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; key_stb = 1'b0;
    chk("R11 head after read+push", int'(head_byte), int'(xlate(51, 1'b0)));
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    chk("R12 avail with one left", int'(rx_avail), 1);
    exp_q.push_back(xlate(52, 1'b1));
    drain("R11 pushed byte kept");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_keys();
    t_cmds();
    t_order();
    t_busy();
    t_full();
    t_empty();
    t_dual();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule